// File: doc/BRIEF.md
# Multi-Bank Clock Divider Network

This block is the digital divider stage of a clock fanout device. It receives source edges as one-clock pulses on a sampling clock: one pulse stream stands for the VCO-rate clock, and two more stand for reference clocks that can be routed straight to the dividers in bypass. All dividers share a single phase counter. From that counter the block derives three output banks and one feedback output. Every output has 50% duty cycle, and all outputs rise together on the first source edge after a restart.

Each bank takes its divide ratio from a global range select and its own one-bit select. The feedback output takes its ratio from the range select and a two-bit code. An active-low hold input parks the bank outputs low. It acts only at phase boundaries and never touches the feedback output. An active-low reset/enable input clears all divider state and drops the driver-enable output, which tells the pad drivers to go to high impedance.

Top module: `zdb_divider_net`

## Requirements
- R1: Banks A and B divide the source by 4 (select 0) or 8 (select 1) when `rng_i`=0, and by 8 or 16 when `rng_i`=1.
- R2: Bank C divides the source by 8 (select 0) or 12 (select 1) when `rng_i`=0, and by 16 or 24 when `rng_i`=1.
- R3: The feedback ratio follows the code {`rng_i`,`fbk_div_i[1]`,`fbk_div_i[0]`}: 000→8, 001→16, 010→12, 011→24, 100→16, 101→32, 110→24, 111→48.
- R4: With ratio N, an output is high for N/2 source edges and then low for N/2. Outputs change only at the clock edge that samples a source pulse. The first source edge after a restart or a reset makes every output rise together. All bits of a bank are equal.
- R5: While `hold_n_i` is low, the bank outputs go low and stay low. A hold that arrives in a high phase lets that phase finish at full width. After release, an output resumes only at the start of a high phase. `hold_n_i` passes through two flip-flops, so a level held for 3 clock cycles before a source edge governs that edge.
- R6: The feedback output toggles normally whether `hold_n_i` is high or low.
- R7: While `en_rst_n_i` is low, `drv_en_o` is 0, every output is 0 and the phase counter returns to its start. `drv_en_o` becomes 1 at the first clock edge after release.
- R8: With `pll_on_i`=1 the source is `vco_tick_i`. With `pll_on_i`=0 the source is `ref0_tick_i` when `ref_pick_i`=0 and `ref1_tick_i` when it is 1. Pulses on the unselected lines have no effect.
- R9: A change on any select input (`pll_on_i`, `ref_pick_i`, `rng_i`, the bank selects, `fbk_div_i`) drives all outputs low at the next clock edge and restarts the common phase, so the next source edge makes every output rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| en_rst_n_i | input | 1 | Active-low asynchronous reset and driver enable |
| pll_on_i | input | 1 | 1: VCO source, 0: reference bypass |
| ref_pick_i | input | 1 | Reference choice in bypass |
| vco_tick_i | input | 1 | One-cycle pulse per VCO edge |
| ref0_tick_i | input | 1 | One-cycle pulse per reference 0 edge |
| ref1_tick_i | input | 1 | One-cycle pulse per reference 1 edge |
| rng_i | input | 1 | Global range (pre-divide) select |
| ratio_a_i | input | 1 | Bank A ratio select |
| ratio_b_i | input | 1 | Bank B ratio select |
| ratio_c_i | input | 1 | Bank C ratio select |
| fbk_div_i | input | 2 | Feedback ratio code |
| hold_n_i | input | 1 | Active-low bank hold |
| bank_a_o | output | A_W | Bank A outputs |
| bank_b_o | output | B_W | Bank B outputs |
| bank_c_o | output | C_W | Bank C outputs |
| fb_o | output | 1 | Feedback output |
| drv_en_o | output | 1 | High when the output drivers may drive |

## Verification
The pulse-width assertions assume that a select input changes only at a restart. Without that, a change of ratio could land in the middle of a high phase. The bench keeps to this by changing selects only between source pulses. It also never sends two source pulses closer than two clocks apart, and it changes `hold_n_i` only when at least three idle clocks follow before the next pulse, so every hold level is fully synchronized. Random pulses are sent on the unselected source lines in the gaps between real pulses, and any leak from those lines would shift the phase the bench predicts.

// File: rtl/zdb_div_pkg.sv
package zdb_div_pkg;
  // Least common multiple of every ratio the block can select.
  localparam int CYC       = 96;
  localparam int CNT_W     = $clog2(CYC);
  localparam int RATIO_W   = 6;
  localparam int NUM_BANKS = 3;

  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    logic       pll_on;
    logic       ref_pick;
    logic       rng;
    logic       sel_a;
    logic       sel_b;
    logic       sel_c;
    logic [1:0] fbk;
  } cfg_t;

  function automatic ratio_t ratio_ab(input logic rng, input logic s);
    ratio_t r;
    r = s ? ratio_t'(8) : ratio_t'(4);
    return rng ? ratio_t'(r << 1) : r;
  endfunction

  function automatic ratio_t ratio_c(input logic rng, input logic s);
    ratio_t r;
    r = s ? ratio_t'(12) : ratio_t'(8);
    return rng ? ratio_t'(r << 1) : r;
  endfunction

  function automatic ratio_t ratio_fb(input logic rng, input logic [1:0] f);
    ratio_t b;
    case (f)
      2'd0:    b = ratio_t'(8);
      2'd1:    b = ratio_t'(16);
      2'd2:    b = ratio_t'(12);
      default: b = ratio_t'(24);
    endcase
    return rng ? ratio_t'(b << 1) : b;
  endfunction

  // High during the first half of each ratio-long window of the counter.
  function automatic logic phase_high(input cnt_t c, input ratio_t n);
    return (int'(c) % int'(n)) < (int'(n) / 2);
  endfunction
endpackage

// File: rtl/zdb_src_mux.sv
module zdb_src_mux (
  input  logic pll_on_i,
  input  logic ref_pick_i,
  input  logic vco_tick_i,
  input  logic ref0_tick_i,
  input  logic ref1_tick_i,
  output logic src_tick_o
);
  always_comb begin
    if (pll_on_i)        src_tick_o = vco_tick_i;
    else if (ref_pick_i) src_tick_o = ref1_tick_i;
    else                 src_tick_o = ref0_tick_i;
  end
endmodule

// File: rtl/zdb_phase_cnt.sv
module zdb_phase_cnt
  import zdb_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic tick_i,
  input  logic restart_i,
  output cnt_t cnt_next_o
);
  localparam cnt_t LAST = cnt_t'(CYC - 1);

  cnt_t cnt_q;

  assign cnt_next_o = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  // Parked on the last count so that the first source edge lands on phase 0.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)       cnt_q <= LAST;
    else if (restart_i) cnt_q <= LAST;
    else if (tick_i)    cnt_q <= cnt_next_o;
  end

  a_r9_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    restart_i |=> (cnt_q == LAST));

  a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    int'(cnt_q) < CYC);
endmodule

// File: rtl/zdb_out_phase.sv
module zdb_out_phase
  import zdb_div_pkg::*;
#(
  parameter bit STOPPABLE = 1'b1
) (
  input  logic   clk_i,
  input  logic   rst_n_i,
  input  logic   tick_i,
  input  logic   restart_i,
  input  cnt_t   cnt_next_i,
  input  ratio_t ratio_i,
  input  logic   stop_req_i,
  output logic   out_o
);
  logic lvl_next;
  logic stopped_q;
  logic stop_nx;
  cnt_t hi_q;

  assign lvl_next = phase_high(cnt_next_i, ratio_i);
  // The hold flag may change only on an edge that opens a low phase.
  assign stop_nx  = STOPPABLE ? (lvl_next ? stopped_q : stop_req_i) : 1'b0;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      out_o     <= 1'b0;
      stopped_q <= 1'b0;
    end else if (restart_i) begin
      out_o     <= 1'b0;
      stopped_q <= STOPPABLE ? stop_req_i : 1'b0;
    end else if (tick_i) begin
      out_o     <= lvl_next & ~stop_nx;
      stopped_q <= stop_nx;
    end
  end

  // Checker state: source edges spent high in the current pulse.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)                            hi_q <= '0;
    else if (restart_i || (tick_i && !out_o)) hi_q <= '0;
    else if (tick_i)                         hi_q <= hi_q + 1'b1;
  end

  a_r4_full_high: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(out_o) |-> ($past(restart_i) ||
                      ($past(hi_q) == cnt_t'(($past(ratio_i) >> 1) - 1'b1))));

  a_r4_change_on_tick: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$stable(out_o) |-> ($past(tick_i) || $past(restart_i)));

  a_r9_restart_low: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    restart_i |=> !out_o);
endmodule

// File: rtl/zdb_divider_net.sv
module zdb_divider_net
  import zdb_div_pkg::*;
#(
  parameter int A_W = 5,
  parameter int B_W = 5,
  parameter int C_W = 4
) (
  input  logic           clk_i,
  input  logic           en_rst_n_i,
  input  logic           pll_on_i,
  input  logic           ref_pick_i,
  input  logic           vco_tick_i,
  input  logic           ref0_tick_i,
  input  logic           ref1_tick_i,
  input  logic           rng_i,
  input  logic           ratio_a_i,
  input  logic           ratio_b_i,
  input  logic           ratio_c_i,
  input  logic [1:0]     fbk_div_i,
  input  logic           hold_n_i,
  output logic [A_W-1:0] bank_a_o,
  output logic [B_W-1:0] bank_b_o,
  output logic [C_W-1:0] bank_c_o,
  output logic           fb_o,
  output logic           drv_en_o
);
  cfg_t                 cfg_now;
  cfg_t                 cfg_q;
  logic                 restart;
  logic                 src_tick;
  logic [1:0]           hold_sync;
  logic                 stop_req;
  cnt_t                 cnt_next;
  ratio_t               bank_ratio [NUM_BANKS];
  ratio_t               fb_ratio;
  logic [NUM_BANKS-1:0] bank_lvl;

  assign cfg_now = '{pll_on: pll_on_i, ref_pick: ref_pick_i, rng: rng_i,
                     sel_a: ratio_a_i, sel_b: ratio_b_i, sel_c: ratio_c_i,
                     fbk: fbk_div_i};
  assign restart  = (cfg_now != cfg_q);
  assign stop_req = ~hold_sync[1];

  always_ff @(posedge clk_i or negedge en_rst_n_i) begin
    if (!en_rst_n_i) begin
      cfg_q     <= '0;
      hold_sync <= 2'b11;
      drv_en_o  <= 1'b0;
    end else begin
      cfg_q     <= cfg_now;
      hold_sync <= {hold_sync[0], hold_n_i};
      drv_en_o  <= 1'b1;
    end
  end

  zdb_src_mux i_src (
    .pll_on_i   (pll_on_i),
    .ref_pick_i (ref_pick_i),
    .vco_tick_i (vco_tick_i),
    .ref0_tick_i(ref0_tick_i),
    .ref1_tick_i(ref1_tick_i),
    .src_tick_o (src_tick)
  );

  zdb_phase_cnt i_cnt (
    .clk_i     (clk_i),
    .rst_n_i   (en_rst_n_i),
    .tick_i    (src_tick),
    .restart_i (restart),
    .cnt_next_o(cnt_next)
  );

  assign bank_ratio[0] = ratio_ab(rng_i, ratio_a_i);
  assign bank_ratio[1] = ratio_ab(rng_i, ratio_b_i);
  assign bank_ratio[2] = ratio_c(rng_i, ratio_c_i);
  assign fb_ratio      = ratio_fb(rng_i, fbk_div_i);

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    zdb_out_phase #(.STOPPABLE(1'b1)) i_phase (
      .clk_i     (clk_i),
      .rst_n_i   (en_rst_n_i),
      .tick_i    (src_tick),
      .restart_i (restart),
      .cnt_next_i(cnt_next),
      .ratio_i   (bank_ratio[gi]),
      .stop_req_i(stop_req),
      .out_o     (bank_lvl[gi])
    );
  end

  zdb_out_phase #(.STOPPABLE(1'b0)) i_fb (
    .clk_i     (clk_i),
    .rst_n_i   (en_rst_n_i),
    .tick_i    (src_tick),
    .restart_i (restart),
    .cnt_next_i(cnt_next),
    .ratio_i   (fb_ratio),
    .stop_req_i(stop_req),
    .out_o     (fb_o)
  );

  assign bank_a_o = {A_W{bank_lvl[0]}};
  assign bank_b_o = {B_W{bank_lvl[1]}};
  assign bank_c_o = {C_W{bank_lvl[2]}};

  a_r7_quiet_when_off: assert property (@(posedge clk_i) disable iff (!en_rst_n_i)
    !drv_en_o |-> (bank_a_o == '0 && bank_b_o == '0 && bank_c_o == '0 && !fb_o));
endmodule

// File: tb/test_zdb_divider_net.sv
module test_zdb_divider_net;
  localparam int A_W = 5;
  localparam int B_W = 5;
  localparam int C_W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic en_rst_n, pll_on, ref_pick, vco_tick, ref0_tick, ref1_tick;
  logic rng, ratio_a, ratio_b, ratio_c, hold_n;
  logic [1:0] fbk_div;
  logic [A_W-1:0] bank_a;
  logic [B_W-1:0] bank_b;
  logic [C_W-1:0] bank_c;
  logic fb, drv_en;

  zdb_divider_net #(.A_W(A_W), .B_W(B_W), .C_W(C_W)) i_zdb_divider_net (
    .clk_i(clk), .en_rst_n_i(en_rst_n), .pll_on_i(pll_on), .ref_pick_i(ref_pick),
    .vco_tick_i(vco_tick), .ref0_tick_i(ref0_tick), .ref1_tick_i(ref1_tick),
    .rng_i(rng), .ratio_a_i(ratio_a), .ratio_b_i(ratio_b), .ratio_c_i(ratio_c),
    .fbk_div_i(fbk_div), .hold_n_i(hold_n),
    .bank_a_o(bank_a), .bank_b_o(bank_b), .bank_c_o(bank_c), .fb_o(fb), .drv_en_o(drv_en)
  );

  int errs = 0, checks = 0, cyc = 0, k = 0;
  bit st[3];
  bit stop_now = 1'b0;
  int ab_tab[4] = '{4, 8, 8, 16};
  int c_tab[4]  = '{8, 12, 16, 24};
  int fb_base[4] = '{8, 16, 12, 24};

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit model_lvl(int kk, int n);
    return ((kk - 1) % n) < (n / 2);
  endfunction

  function automatic bit all_low();
    return bank_a == 0 && bank_b == 0 && bank_c == 0 && fb == 1'b0;
  endfunction

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      vco_tick = 0; ref0_tick = 0; ref1_tick = 0;
    end
  endtask

  task automatic apply_cfg(bit rg, bit sa, bit sb, bit sc, bit [1:0] fbk, bit pl, bit rp);
    bit changed;
    @(negedge clk);
    changed = {rg, sa, sb, sc, fbk, pl, rp} !=
              {rng, ratio_a, ratio_b, ratio_c, fbk_div, pll_on, ref_pick};
    rng = rg; ratio_a = sa; ratio_b = sb; ratio_c = sc; fbk_div = fbk;
    pll_on = pl; ref_pick = rp;
    vco_tick = 0; ref0_tick = 0; ref1_tick = 0;
    @(negedge clk);
    if (changed) begin
      chk(all_low(), "R9", "outputs low after select change", int'(bank_a), 0);
      k = 0;
      for (int b = 0; b < 3; b++) st[b] = stop_now;
    end
    idle(2);
  endtask

  task automatic set_hold(bit stop);
    @(negedge clk);
    hold_n = !stop;
    stop_now = stop;
    idle(3);
  endtask

  task automatic do_reset();
    @(negedge clk);
    en_rst_n = 1'b0;
    idle(2);
    chk(drv_en == 1'b0, "R7", "drv_en during reset", int'(drv_en), 0);
    chk(all_low(), "R7", "outputs during reset", int'(bank_a), 0);
    @(negedge clk);
    en_rst_n = 1'b1;
    @(negedge clk);
    chk(drv_en == 1'b1, "R7", "drv_en after release", int'(drv_en), 1);
    idle(2);
    k = 0;
    for (int b = 0; b < 3; b++) st[b] = 1'b0;
  endtask

  task automatic run_ticks(int n, string tag);
    int na, nb, nc, nf;
    bit ea, eb, ec, ef;
    na = ab_tab[{rng, ratio_a}];
    nb = ab_tab[{rng, ratio_b}];
    nc = c_tab[{rng, ratio_c}];
    nf = fb_base[fbk_div] * (rng ? 2 : 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vco_tick  = pll_on;
      ref0_tick = !pll_on && !ref_pick;
      ref1_tick = !pll_on && ref_pick;
      @(negedge clk);
      vco_tick = 0; ref0_tick = 0; ref1_tick = 0;
      k++;
      ea = model_lvl(k, na); eb = model_lvl(k, nb); ec = model_lvl(k, nc); ef = model_lvl(k, nf);
      if (!ea) st[0] = stop_now;
      if (!eb) st[1] = stop_now;
      if (!ec) st[2] = stop_now;
      ea = ea && !st[0]; eb = eb && !st[1]; ec = ec && !st[2];
      chk(bank_a == (ea ? {A_W{1'b1}} : {A_W{1'b0}}), tag, "bank A (R1 R4)", int'(bank_a), ea ? 31 : 0);
      chk(bank_b == (eb ? {B_W{1'b1}} : {B_W{1'b0}}), tag, "bank B (R1 R4)", int'(bank_b), eb ? 31 : 0);
      chk(bank_c == (ec ? {C_W{1'b1}} : {C_W{1'b0}}), tag, "bank C (R2 R4)", int'(bank_c), ec ? 15 : 0);
      chk(fb == ef, tag, "feedback (R3 R6)", int'(fb), int'(ef));
      // Noise on the lines that are not selected (R8).
      if (pll_on) begin
        ref0_tick = 1'($urandom % 2); ref1_tick = 1'($urandom % 2);
      end else begin
        vco_tick = 1'($urandom % 2);
        if (ref_pick) ref0_tick = 1'($urandom % 2);
        else          ref1_tick = 1'($urandom % 2);
      end
    end
    idle(1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    en_rst_n = 0; pll_on = 1; ref_pick = 0; vco_tick = 0; ref0_tick = 0; ref1_tick = 0;
    rng = 0; ratio_a = 0; ratio_b = 0; ratio_c = 0; fbk_div = 0; hold_n = 1;
    idle(3);
    chk(drv_en == 1'b0 && all_low(), "R7", "reset state", int'(drv_en), 0);
    en_rst_n = 1;
    @(negedge clk);
    chk(drv_en == 1'b1, "R7", "drv_en after first release", int'(drv_en), 1);
    idle(2);
    k = 0;

    // Every select value with the VCO source.
    for (int r = 0; r < 2; r++)
      for (int f = 0; f < 4; f++) begin
        apply_cfg(r[0], f[0], f[1], !f[0], f[1:0], 1'b1, 1'b0);
        run_ticks(96, "R1 R2 R3 R4");
      end

    // Bypass through each reference.
    apply_cfg(1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0);
    run_ticks(48, "R8");
    apply_cfg(1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1);
    run_ticks(48, "R8");

    // Hold from the start, then across a high phase, then release.
    apply_cfg(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0);
    set_hold(1'b1);
    apply_cfg(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
    run_ticks(24, "R5 R6");
    set_hold(1'b0);
    run_ticks(25, "R5");
    set_hold(1'b1);
    run_ticks(24, "R5 R6");
    set_hold(1'b0);
    run_ticks(24, "R5");

    // Reset in the middle of activity.
    run_ticks(5, "R4");
    do_reset();
    run_ticks(24, "R7 R4");

    // Random mix.
    for (int it = 0; it < 24; it++) begin
      apply_cfg(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2));
      if ($urandom % 3 == 0) set_hold(!stop_now);
      if ($urandom % 8 == 0) do_reset();
      run_ticks(20 + int'($urandom % 80), "R1 R2 R3 R5 R8 R9");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule